// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Binary Counter

This block is a wide synchronous up-counter built from identical 4-bit slices. It counts in binary and can be preset from a parallel data bus. It has two count enables. The first, a plain enable, goes to every slice. The second, a trickle enable, enters the lowest slice. Each slice passes a terminal-count flag to the next slice's trickle input, so an upper slice advances only when every slice below it holds all ones. All slices share one clock and one load strobe, so every bit changes on the same rising edge.

The clear input is active low. A build-time parameter makes it either asynchronous or synchronous. The asynchronous clear zeroes the count at once. The synchronous clear zeroes it at the next rising edge. In the synchronous build, the clear input can be driven from a decoded count. This makes the counter roll over early, at a chosen value. The terminal-count output of the top slice marks a full count. A further counter of the same kind can be chained onto it.

Top module: `wide_sync_counter`

## Requirements
- R1: A low on `clr_n` zeroes `q`. With `ASYNC_CLR=1` this happens without waiting for a clock edge. With `ASYNC_CLR=0` it happens at the next rising edge and overrides load and both enables.
- R2: When `load_n` is low at a rising edge and no clear is active, `q` takes the value of `din`, whatever the levels of `cnt_en_p` and `cnt_en_t`.
- R3: When `load_n` is high and both `cnt_en_p` and `cnt_en_t` are high, `q` increases by one at the rising edge.
- R4: When `load_n` is high and either enable is low, `q` holds its value.
- R5: A count step from all ones (0xFF with default parameters) gives zero.
- R6: `tc_out` is 1 only when `cnt_en_t` is 1, `clr_n` is 1 and every bit of `q` is 1. It is 0 otherwise, including while the clear is held low.
- R7: Slice k (bits k*WIDTH upward) changes on a count step only when all lower bits are ones. For example, 0x0F steps to 0x10 and 0x0E steps to 0x0F.
- R8: With `ASYNC_CLR=0`, driving `clr_n` low whenever `q` equals 6 makes the counter cycle through 0 to 6 and return to 0, a cycle of seven states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all slices |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous by parameter |
| load_n | input | 1 | Active-low parallel preset strobe |
| cnt_en_p | input | 1 | Count enable routed to every slice |
| cnt_en_t | input | 1 | Trickle count enable into the lowest slice; also gates `tc_out` |
| din | input | STAGES*WIDTH | Preset value |
| q | output | STAGES*WIDTH | Registered count |
| tc_out | output | 1 | Terminal count of the top slice |

## Verification
The bench aims at the places where the priorities and the cascade most often go wrong. It asserts clear and load together: a design that ranks load above the synchronous clear would come out holding the preset value. It checks the asynchronous clear partway through a cycle and the synchronous clear just before the edge, so a design that mixes up the two builds shows the wrong value in that window. It checks the carry across a slice boundary and the wrap from all ones, where a broken trickle chain would let the upper slice run free or stay still. It toggles the trickle enable at full count: a design that gates the terminal count with the plain enable, or ignores the clear, shows a wrong `tc_out`. It also checks the seven-state truncated cycle, which a clear taking effect too early or too late would lengthen or shorten.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    M_HOLD  = 2'd0,
    M_COUNT = 2'd1,
    M_LOAD  = 2'd2,
    M_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec #(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic                clr_n,
  input  logic                load_n,
  input  logic                en_p,
  input  logic                en_t,
  output wsc_pkg::cnt_mode_e  mode
);
  import wsc_pkg::*;

  // Priority: clear (sync build only), preset, count, hold
  always_comb begin
    if (SYNC_CLR && !clr_n)  mode = M_CLEAR;
    else if (!load_n)        mode = M_LOAD;
    else if (en_p && en_t)   mode = M_COUNT;
    else                     mode = M_HOLD;
  end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  import wsc_pkg::*;

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  cnt_mode_e        mode;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  cnt_mode_dec #(.SYNC_CLR(!ASYNC_CLR)) u_dec (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  always_comb begin
    unique case (mode)
      M_CLEAR: q_nxt = '0;
      M_LOAD:  q_nxt = din;
      M_COUNT: q_nxt = q_r + ONE;
      default: q_nxt = q_r;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      // R1: clear level holds the register at zero
      assert_aclr_zero_R1: assert property (@(posedge clk)
        !clr_n |-> q_r == '0);
    end else begin : g_sclr
      always_ff @(posedge clk) begin
        q_r <= q_nxt;
      end

      // R1: synchronous clear wins over every other mode
      assert_sclr_zero_R1: assert property (@(posedge clk)
        !clr_n |=> q_r == '0);
    end
  endgenerate

  assign q  = q_r;
  assign tc = en_t & clr_n & (&q_r);

  assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q_r == $past(din));

  assert_count_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q_r == WIDTH'($past(q_r) + ONE));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q_r));
endmodule

// File: rtl/wide_sync_counter.sv
module wide_sync_counter #(
  parameter int STAGES    = 2,
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic                      clk,
  input  logic                      clr_n,
  input  logic                      load_n,
  input  logic                      cnt_en_p,
  input  logic                      cnt_en_t,
  input  logic [STAGES*WIDTH-1:0]   din,
  output logic [STAGES*WIDTH-1:0]   q,
  output logic                      tc_out
);
  localparam int TOTAL = STAGES * WIDTH;

  logic [STAGES:0] t_chain;

  assign t_chain[0] = cnt_en_t;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_slice
      cnt_slice #(
        .WIDTH     (WIDTH),
        .ASYNC_CLR (ASYNC_CLR)
      ) u_slice (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (cnt_en_p),
        .en_t   (t_chain[i]),
        .din    (din[i*WIDTH +: WIDTH]),
        .q      (q[i*WIDTH +: WIDTH]),
        .tc     (t_chain[i+1])
      );

      if (i > 0) begin : g_casc
        // R7: an upper slice stays put unless every lower bit is one
        assert_cascade_R7: assert property (@(posedge clk) disable iff (!clr_n)
          (load_n && !(&q[i*WIDTH-1:0])) |=> $stable(q[i*WIDTH +: WIDTH]));
      end
    end
  endgenerate

  assign tc_out = t_chain[STAGES];

  // R6: full count flag requires all ones and the trickle enable
  assert_tc_full_R6: assert property (@(posedge clk)
    tc_out |-> (cnt_en_t && (&q) && clr_n));

  assert_tc_set_R6: assert property (@(posedge clk)
    (cnt_en_t && clr_n && (&q)) |-> tc_out);

  // R5: a count step from all ones lands on zero
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en_p && cnt_en_t && (&q)) |=> q == TOTAL'(0));
endmodule

// File: tb/wide_sync_counter_tb.sv
module wide_sync_counter_tb;
  localparam int STAGES = 2;
  localparam int WIDTH  = 4;
  localparam int TOT    = STAGES * WIDTH;

  logic           clk = 1'b0;
  logic           clr_s_n, clr_a_n, load_n, en_p, en_t;
  logic [TOT-1:0] din;
  logic [TOT-1:0] q_s, q_a;
  logic           tc_s, tc_a;
  logic [TOT-1:0] m_s, m_a;
  int             checks = 0;
  int             failures = 0;
  bit             done = 1'b0;

  always #4 clk = ~clk;

  wide_sync_counter #(.STAGES(STAGES), .WIDTH(WIDTH), .ASYNC_CLR(1'b0)) u_dut (
    .clk(clk), .clr_n(clr_s_n), .load_n(load_n), .cnt_en_p(en_p),
    .cnt_en_t(en_t), .din(din), .q(q_s), .tc_out(tc_s));

  wide_sync_counter #(.STAGES(STAGES), .WIDTH(WIDTH), .ASYNC_CLR(1'b1)) u_dut_async (
    .clk(clk), .clr_n(clr_a_n), .load_n(load_n), .cnt_en_p(en_p),
    .cnt_en_t(en_t), .din(din), .q(q_a), .tc_out(tc_a));

  // Behavioural reference models built from R1..R4
  always @(posedge clk) begin
    if (!clr_s_n)          m_s <= '0;
    else if (!load_n)      m_s <= din;
    else if (en_p && en_t) m_s <= m_s + 1'b1;
  end

  always @(posedge clk or negedge clr_a_n) begin
    if (!clr_a_n)          m_a <= '0;
    else if (!load_n)      m_a <= din;
    else if (en_p && en_t) m_a <= m_a + 1'b1;
  end

  task automatic chk(input string tag, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_models(input string tag);
    chk({tag, " model sync"},  q_s, m_s);
    chk({tag, " model async"}, q_a, m_a);
  endtask

  task automatic t_reset();
    chk("R1 reset sync q", q_s, '0);
    chk("R1 reset async q", q_a, '0);
    chk("R6 reset tc sync", TOT'(tc_s), '0);
  endtask

  task automatic t_load_hold();
    load_n = 1'b0; en_p = 1'b0; en_t = 1'b0; din = 8'hA5;
    tick();
    chk("R2 load enables low", q_s, 8'hA5);
    chk("R2 load async build", q_a, 8'hA5);
    load_n = 1'b1; en_p = 1'b1; en_t = 1'b0;
    tick();
    chk("R4 hold trickle low", q_s, 8'hA5);
    en_p = 1'b0; en_t = 1'b1;
    tick();
    chk("R4 hold plain low", q_s, 8'hA5);
    cmp_models("R4");
  endtask

  task automatic t_count_cascade();
    load_n = 1'b0; din = 8'h0E; en_p = 1'b0; en_t = 1'b0;
    tick();
    load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk("R3 step 0E->0F", q_s, 8'h0F);
    chk("R7 upper slice still at 0", TOT'(q_s[7:4]), '0);
    tick();
    chk("R7 carry 0F->10", q_s, 8'h10);
    tick();
    chk("R3 step 10->11", q_s, 8'h11);
    cmp_models("R3");
  endtask

  task automatic t_wrap_tc();
    load_n = 1'b0; din = 8'hFE; en_p = 1'b1; en_t = 1'b1;
    tick();
    load_n = 1'b1;
    chk("R6 tc low at FE", TOT'(tc_s), '0);
    tick();
    chk("R3 step to FF", q_s, 8'hFF);
    chk("R6 tc high at FF", TOT'(tc_s), 1);
    en_t = 1'b0;
    #1;
    chk("R6 tc drops with trickle low", TOT'(tc_s), '0);
    chk("R6 tc async drops with trickle low", TOT'(tc_a), '0);
    en_t = 1'b1; en_p = 1'b0;
    #1;
    chk("R6 tc high with plain enable low", TOT'(tc_s), 1);
    clr_s_n = 1'b0;
    #1;
    chk("R6 tc low during clear", TOT'(tc_s), '0);
    clr_s_n = 1'b1; en_p = 1'b1;
    tick();
    chk("R5 wrap FF->00", q_s, 8'h00);
    chk("R5 wrap async build", q_a, 8'h00);
    cmp_models("R5");
  endtask

  task automatic t_clear_priority();
    load_n = 1'b0; din = 8'h5A; en_p = 1'b0; en_t = 1'b0;
    tick();
    din = 8'hC3; en_p = 1'b1; en_t = 1'b1;
    #2;
    clr_s_n = 1'b0; clr_a_n = 1'b0;
    #1;
    chk("R1 async clears mid-cycle", q_a, '0);
    chk("R1 sync waits for edge", q_s, 8'h5A);
    tick();
    chk("R1 sync clear beats load", q_s, '0);
    chk("R1 async held clear", q_a, '0);
    clr_s_n = 1'b1; clr_a_n = 1'b1; load_n = 1'b1;
    tick();
    chk("R3 count after clear", q_s, 8'h01);
    cmp_models("R1");
  endtask

  task automatic t_truncate();
    int max_seen = 0;
    int zeros = 0;
    clr_s_n = 1'b0; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    tick();
    clr_s_n = 1'b1;
    for (int k = 0; k < 21; k++) begin
      clr_s_n = (q_s != 8'd6);
      tick();
      if (int'(q_s) > max_seen) max_seen = int'(q_s);
      if (q_s == 8'd0) zeros++;
    end
    clr_s_n = 1'b1;
    chk("R8 truncated max", TOT'(max_seen), 8'd6);
    chk("R8 truncated cycles", TOT'(zeros), 8'd3);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr_s_n = 1'b1; clr_a_n = 1'b1; load_n = 1'b1;
    en_p = 1'b0; en_t = 1'b0; din = '0;
    #2;
    clr_s_n = 1'b0; clr_a_n = 1'b0;
    tick();
    tick();
    t_reset();
    clr_s_n = 1'b1; clr_a_n = 1'b1;
    t_load_hold();
    t_count_cascade();
    t_wrap_tc();
    t_clear_priority();
    t_truncate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule